// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with Compare

This block is a 32-bit down-counting periodic timer controlled through a small synchronous register port. Software programs a start value, a compare value and a control word. The counter then decrements once per prescaled tick. The tick comes from one of three single-cycle pulse inputs, and the selected pulses are divided by a programmable prescale factor.

When a decrement lands the counter on the compare value, a sticky flag is set. That flag drives the interrupt line while both enable bits allow it. When the counter passes zero it either reloads from the load register or wraps to all ones. A software reset bit returns most of the state to its defaults and leaves the enable and low-power bits as they were.

The register port is word-addressed: `bus_addr` carries the byte address with its two low bits dropped. Reads return data one cycle after the request. The output-pin mode bits and the low-power and debug bits are storage only.

Top module: `reload_timer`

## Requirements
- R1: Word address 0 selects control, 1 status, 2 load, 3 compare and 4 the counter. The counter word is read-only. Any other word reads as zero and ignores writes. After reset, control, status, compare and counter read 0 and load reads 0xFFFFFFFF.
- R2: A control write stores only bits 25:0. Bits 31:26 read back as zero.
- R3: Clock-source field control[25:24] selects the tick input. Code 1 selects tick_src[0], code 2 selects tick_src[1] and code 3 selects tick_src[2]. Code 0 selects nothing, so the counter holds.
- R4: With prescale field control[15:4] = P, the counter decrements once per P+1 pulses of the selected source while enabled.
- R5: irq is high exactly when the status flag (status bit 0), control bit 2 (compare interrupt enable) and control bit 0 (enable) are all set.
- R6: Writing status with data bit 0 = 1 clears the flag. Data bit 0 = 0 leaves it unchanged. If a compare event happens in the same cycle as the clear, the flag stays set.
- R7: The flag is set when a decrement makes the counter equal to the compare value.
- R8: Writing control with bit 16 set does the following. The control word keeps only bits 0, 1, 18, 19, 20 and 21 of the written value and clears all others, including bit 16. Status and compare become 0 and load becomes 0xFFFFFFFF. The counter becomes 0xFFFFFFFF if the written bit 0 is set, and 0 otherwise.
- R9: A control write that takes bit 0 from 0 to 1 with bit 1 set starts the counter. It starts from the load value if bit 3 is set, and from 0xFFFFFFFF otherwise.
- R10: With bit 0 clear the counter holds. When bit 0 goes from 0 to 1 with bit 1 clear, counting resumes from the held value.
- R11: A decrement from zero reloads the load value when control bit 3 is set, and wraps to 0xFFFFFFFF when it is clear.
- R12: A load write while control bit 17 is set also copies the written value into the counter at once. Without bit 17 the counter is untouched.
- R13: bus_rdata presents the addressed register's value one cycle after a read request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | NUM_SRC | Single-cycle tick pulses, one per source |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (byte address bits above 1:0) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Compare interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the counter stays put whenever it is disabled or its source code is zero and no write is in flight;
- irq never rises without both enables;
- a status clear with no coincident event empties the flag;
- a compare event always leaves the flag set;
- a read of control returns zero upper bits;
- a software reset leaves bit 16 clear and load at all ones;
- a decrement from zero with reload selected takes the load value.

Other behaviour only the bench's scenarios can show, by comparing every read and the interrupt line against an independent model. This covers the start value chosen on enable, the prescale division ratio, the routing of each source code, the immediate overwrite on a load write, and the long mixed sequences of writes and ticks.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int SRC_W = 2;
    localparam int PRE_W = 12;
    localparam int CTRL_W = 26;

    // Control word: field order matches the bit positions, bit 0 last.
    typedef struct packed {
        logic [SRC_W-1:0] src;      // 25:24
        logic [1:0]       outmode;  // 23:22 storage only
        logic             stop_en;  // 21
        logic             doze_en;  // 20
        logic             wait_en;  // 19
        logic             dbg_en;   // 18
        logic             ovw;      // 17
        logic             swr;      // 16
        logic [PRE_W-1:0] pre;      // 15:4
        logic             rld;      // 3
        logic             ocie;     // 2
        logic             enmod;    // 1
        logic             en;       // 0
    } ctrl_t;

    localparam int W_CTRL = 0;
    localparam int W_STAT = 1;
    localparam int W_LOAD = 2;
    localparam int W_CMP  = 3;
    localparam int W_CNT  = 4;

    // Fields that survive a software reset.
    function automatic ctrl_t keep_on_swr(ctrl_t c);
        ctrl_t k;
        k = '0;
        k.en      = c.en;
        k.enmod   = c.enmod;
        k.dbg_en  = c.dbg_en;
        k.wait_en = c.wait_en;
        k.doze_en = c.doze_en;
        k.stop_en = c.stop_en;
        return k;
    endfunction

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
    parameter int NUM_SRC = 3,
    parameter int PRE_W   = rt_pkg::PRE_W,
    parameter int SRC_W   = rt_pkg::SRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic [SRC_W-1:0]   src_sel,
    input  logic [PRE_W-1:0]   prescale,
    input  logic               run,
    output logic               tick
);

    typedef struct packed {
        logic [PRE_W-1:0] pc;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_SRC-1:0] gated;
    logic raw;

    // One gate per source: code k+1 routes tick_src[k].
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        assign gated[k] = tick_src[k] && (src_sel == SRC_W'(k + 1));
    end

    assign raw = |gated;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.pc = '0;
        end else if (raw) begin
            if (st_q.pc >= prescale) begin
                st_d.pc = '0;
                tick    = 1'b1;
            end else begin
                st_d.pc = st_q.pc + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload_sel,
    input  logic [CNT_W-1:0] load_val,
    input  logic             force_en,
    input  logic [CNT_W-1:0] force_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (force_en) begin
            st_d.cnt = force_val;
        end else if (tick) begin
            if (st_q.cnt == '0) st_d.cnt = reload_sel ? load_val : CNT_MAX;
            else                st_d.cnt = st_q.cnt - CNT_W'(1);
            hit = (st_d.cnt == cmp_val);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int ADDR_W  = 10,
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic               irq
);
    import rt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic             wr_req, rd_req;
    logic             force_en;
    logic [CNT_W-1:0] force_val;
    logic             tick, hit;
    logic [CNT_W-1:0] count;
    ctrl_t            new_ctrl;

    // Plain views of state for the bound checker.
    ctrl_t            ctrl_cur;
    logic             flag_cur;
    logic [CNT_W-1:0] load_cur;

    assign wr_req   = bus_sel && bus_wr;
    assign rd_req   = bus_sel && !bus_wr;
    assign new_ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign ctrl_cur = st_q.ctrl;
    assign flag_cur = st_q.flag;
    assign load_cur = st_q.load;

    rt_tick_gen #(
        .NUM_SRC(NUM_SRC),
        .PRE_W  (PRE_W),
        .SRC_W  (SRC_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_src(tick_src),
        .src_sel (st_q.ctrl.src),
        .prescale(st_q.ctrl.pre),
        .run     (st_q.ctrl.en),
        .tick    (tick)
    );

    rt_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reload_sel(st_q.ctrl.rld),
        .load_val  (st_q.load),
        .force_en  (force_en),
        .force_val (force_val),
        .cmp_val   (st_q.cmp),
        .count     (count),
        .hit       (hit)
    );

    always_comb begin
        st_d      = st_q;
        force_en  = 1'b0;
        force_val = '0;

        // Flag: clear request first, compare event wins over it.
        if (wr_req && bus_addr == ADDR_W'(W_STAT) && bus_wdata[0]) st_d.flag = 1'b0;
        if (hit) st_d.flag = 1'b1;

        if (wr_req) begin
            if (bus_addr == ADDR_W'(W_CTRL)) begin
                if (new_ctrl.swr) begin
                    st_d.ctrl = keep_on_swr(new_ctrl);
                    st_d.flag = 1'b0;
                    st_d.load = CNT_MAX;
                    st_d.cmp  = '0;
                    force_en  = 1'b1;
                    force_val = new_ctrl.en ? CNT_MAX : '0;
                end else begin
                    st_d.ctrl = new_ctrl;
                    if (new_ctrl.en && !st_q.ctrl.en && new_ctrl.enmod) begin
                        force_en  = 1'b1;
                        force_val = new_ctrl.rld ? st_q.load : CNT_MAX;
                    end
                end
            end else if (bus_addr == ADDR_W'(W_LOAD)) begin
                st_d.load = bus_wdata;
                if (st_q.ctrl.ovw) begin
                    force_en  = 1'b1;
                    force_val = bus_wdata;
                end
            end else if (bus_addr == ADDR_W'(W_CMP)) begin
                st_d.cmp = bus_wdata;
            end
        end

        if (rd_req) begin
            if      (bus_addr == ADDR_W'(W_CTRL)) st_d.rdata = CNT_W'(st_q.ctrl);
            else if (bus_addr == ADDR_W'(W_STAT)) st_d.rdata = CNT_W'(st_q.flag);
            else if (bus_addr == ADDR_W'(W_LOAD)) st_d.rdata = st_q.load;
            else if (bus_addr == ADDR_W'(W_CMP))  st_d.rdata = st_q.cmp;
            else if (bus_addr == ADDR_W'(W_CNT))  st_d.rdata = count;
            else                                  st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.load  <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = st_q.flag && st_q.ctrl.en && st_q.ctrl.ocie;

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd_bit0,
    input logic              wd_swr,
    input logic [CNT_W-1:0]  bus_rdata,
    input logic              irq,
    input rt_pkg::ctrl_t     ctrl_cur,
    input logic              flag_cur,
    input logic [CNT_W-1:0]  load_cur,
    input logic [CNT_W-1:0]  count,
    input logic              tick,
    input logic              hit
);

    logic wr_any;
    assign wr_any = bus_sel && bus_wr;

    // R10
    en_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_cur.en && !wr_any) |=> $stable(count));

    // R3
    src_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_cur.src == '0 && !wr_any) |=> $stable(count));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_cur.en && ctrl_cur.ocie));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(rt_pkg::W_STAT) && wd_bit0 && !hit) |=> !flag_cur);

    // R7
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_cur);

    // R2
    ctrl_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(rt_pkg::W_CTRL))
        |=> (bus_rdata[CNT_W-1:rt_pkg::CTRL_W] == '0));

    // R8
    swr_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == ADDR_W'(rt_pkg::W_CTRL) && wd_swr)
        |=> (!ctrl_cur.swr && load_cur == '1 && !flag_cur));

    // R11
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0 && ctrl_cur.rld && !wr_any) |=> (count == $past(load_cur)));

endmodule

bind reload_timer rt_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wd_bit0  (bus_wdata[0]),
    .wd_swr   (bus_wdata[16]),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .ctrl_cur (ctrl_cur),
    .flag_cur (flag_cur),
    .load_cur (load_cur),
    .count    (count),
    .tick     (tick),
    .hit      (hit)
);

// File: tb/tb_reload_timer.sv
module tb_reload_timer;

    localparam int ADDR_W = 10;
    localparam int CNT_W  = 32;
    localparam int NSRC   = 3;
    localparam logic [31:0] MAXV = 32'hFFFF_FFFF;
    localparam logic [25:0] KEEP = 26'h03C_0003;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   ticks = '0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    reload_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_SRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .tick_src(ticks), .bus_sel(sel), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // Independent behavioural model written from the requirements.
    logic [25:0] m_ctrl;
    logic        m_flag;
    logic [31:0] m_load, m_cmp, m_cnt;
    logic [11:0] m_pc;

    always @(posedge clk) begin
        logic [1:0]  src;
        logic        raw, tk, forced;
        logic [25:0] nctrl;
        logic        nflag;
        logic [31:0] nload, ncmp, ncnt;
        logic [11:0] npc;
        if (!rst_n) begin
            m_ctrl = '0; m_flag = 1'b0; m_load = MAXV; m_cmp = '0; m_cnt = '0; m_pc = '0;
        end else begin
            src = m_ctrl[25:24];
            raw = (src != 2'd0) && ticks[src - 2'd1];
            tk = 1'b0; npc = m_pc;
            if (!m_ctrl[0]) npc = '0;
            else if (raw) begin
                if (m_pc >= m_ctrl[15:4]) begin npc = '0; tk = 1'b1; end
                else npc = m_pc + 12'd1;
            end
            nctrl = m_ctrl; nflag = m_flag; nload = m_load; ncmp = m_cmp; ncnt = m_cnt;
            forced = 1'b0;
            if (sel && wr) begin
                case (addr)
                    10'd0: if (wdata[16]) begin
                        nctrl = wdata[25:0] & KEEP; nflag = 1'b0; nload = MAXV; ncmp = '0;
                        ncnt = wdata[0] ? MAXV : 32'd0; forced = 1'b1;
                    end else begin
                        nctrl = wdata[25:0];
                        if (wdata[0] && !m_ctrl[0] && wdata[1]) begin
                            ncnt = wdata[3] ? m_load : MAXV; forced = 1'b1;
                        end
                    end
                    10'd1: if (wdata[0]) nflag = 1'b0;
                    10'd2: begin
                        nload = wdata;
                        if (m_ctrl[17]) begin ncnt = wdata; forced = 1'b1; end
                    end
                    10'd3: ncmp = wdata;
                    default: ;
                endcase
            end
            if (!forced && tk) begin
                ncnt = (m_cnt == 0) ? (m_ctrl[3] ? m_load : MAXV) : m_cnt - 32'd1;
                if (ncnt == m_cmp) nflag = 1'b1;
            end
            m_ctrl = nctrl; m_flag = nflag; m_load = nload; m_cmp = ncmp;
            m_cnt = ncnt; m_pc = npc;
        end
    end

    function automatic logic [31:0] mread(input logic [ADDR_W-1:0] a);
        case (a)
            10'd0:   return {6'd0, m_ctrl};
            10'd1:   return {31'd0, m_flag};
            10'd2:   return m_load;
            10'd3:   return m_cmp;
            10'd4:   return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        return m_flag && m_ctrl[0] && m_ctrl[2];
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        logic [31:0] e;
        e = mread(a);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        chk(tag, rdata, e);
    endtask

    task automatic rd_lit(input logic [ADDR_W-1:0] a, input logic [31:0] v, input string tag);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        chk(tag, rdata, v);
    endtask

    task automatic pulse(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            ticks = NSRC'(1) << k;
            @(negedge clk);
            ticks = '0;
        end
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {31'd0, irq}, {31'd0, m_irq()});
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and decode
        rd_lit(0, 32'd0, "R1 ctrl reset");
        rd_lit(1, 32'd0, "R1 stat reset");
        rd_lit(2, MAXV,  "R1 load reset");
        rd_lit(4, 32'd0, "R1 cnt reset");
        write(6, 32'h1234);
        rd_lit(6, 32'd0, "R1 unmapped word");
        write(4, 32'h55);
        rd_lit(4, 32'd0, "R1 counter read-only");

        // R2 upper control bits dropped
        write(0, 32'hFC30_0000);
        rd_lit(0, 32'h0030_0000, "R2 ctrl upper zero");
        write(0, 32'd0);

        // R9 start from load with reload bit; R3 source routing; R13 latency
        write(2, 32'd10);
        write(0, 32'h0100_000B);            // src1, rld, enmod, en
        rd_lit(4, 32'd10, "R9 start from load");
        pulse(0, 3);
        rd_lit(4, 32'd7, "R3 src1 decrements");
        pulse(1, 2); pulse(2, 2);
        rd_lit(4, 32'd7, "R3 other sources ignored");
        rd(4, "R13 read data");

        // R7 compare, R5 irq, R6 clear
        write(3, 32'd5);
        pulse(0, 2);
        rd_lit(1, 32'd1, "R7 flag on compare");
        chk("R5 irq masked", {31'd0, irq}, 32'd0);
        write(0, 32'h0100_000F);            // add ocie
        chk("R5 irq raised", {31'd0, irq}, 32'd1);
        write(1, 32'd0);
        rd_lit(1, 32'd1, "R6 zero write keeps flag");
        write(1, 32'd1);
        rd_lit(1, 32'd0, "R6 clear flag");
        chk_irq("R5 irq after clear");

        // R11 reload at zero, then wrap with reload clear
        pulse(0, 6);
        rd_lit(4, 32'd10, "R11 reload from load");
        write(0, 32'h0100_0007);            // drop rld
        write(2, 32'd0);
        pulse(0, 11);
        rd_lit(4, MAXV, "R11 wrap to max");

        // R12 overwrite on load write
        write(0, 32'h0102_0007);
        write(2, 32'd100);
        rd_lit(4, 32'd100, "R12 overwrite");
        write(0, 32'h0100_0007);
        write(2, 32'd50);
        rd_lit(4, 32'd100, "R12 no overwrite");

        // R10 hold when disabled, resume with enmod clear
        write(0, 32'h0100_0000);
        pulse(0, 4);
        rd_lit(4, 32'd100, "R10 disabled holds");
        write(0, 32'h0100_0001);
        pulse(0, 1);
        rd_lit(4, 32'd99, "R10 resume from held");

        // R9 start from max without reload bit
        write(0, 32'h0100_0000);
        write(0, 32'h0100_0003);
        rd_lit(4, MAXV, "R9 start from max");

        // R3 source code 0 holds
        write(0, 32'h0000_0001);
        pulse(0, 2); pulse(1, 2); pulse(2, 2);
        rd_lit(4, MAXV, "R3 code0 holds");

        // R4 prescale 2 -> one decrement per 3 pulses on source 3
        write(0, 32'h0300_0021);
        pulse(2, 5);
        rd_lit(4, MAXV - 32'd1, "R4 prescale partial");
        pulse(2, 1);
        rd_lit(4, MAXV - 32'd2, "R4 prescale full");

        // R8 software reset keeps enable and low-power bits
        write(3, 32'd9); write(2, 32'd77);
        write(0, 32'h03FF_FFF1);
        rd_lit(0, 32'h003C_0001, "R8 ctrl kept bits");
        rd_lit(2, MAXV,  "R8 load default");
        rd_lit(3, 32'd0, "R8 cmp cleared");
        rd_lit(4, MAXV,  "R8 counter restart");
        write(0, 32'h0001_0000);
        rd_lit(4, 32'd0, "R8 counter zero when disabled");

        // Mixed random stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [31:0] e;
            logic [ADDR_W-1:0] a;
            op = int'($urandom % 8);
            ticks = NSRC'($urandom % 8);
            a = ADDR_W'($urandom % 6);
            e = mread(a);
            sel = 1'b0; wr = 1'b0;
            case (op)
                0, 1: begin sel = 1'b1; addr = a; end
                2: begin
                    sel = 1'b1; wr = 1'b1; addr = 0;
                    wdata = $urandom & 32'hFFFE_FFFF & ~32'h0000_FFF0;
                    wdata[5:4] = 2'($urandom % 3);
                    if ($urandom % 10 == 0) wdata[16] = 1'b1;
                end
                3: begin sel = 1'b1; wr = 1'b1; addr = 2; wdata = $urandom % 40; end
                4: begin sel = 1'b1; wr = 1'b1; addr = 3; wdata = $urandom % 40; end
                5: begin sel = 1'b1; wr = 1'b1; addr = 1; wdata = $urandom % 2; end
                default: ;
            endcase
            @(negedge clk);
            if (op <= 1) chk("R13 random read", rdata, e);
            chk_irq("R5 random irq");
            sel = 1'b0; wr = 1'b0; ticks = '0;
        end
        for (int w = 0; w < 5; w++) rd(ADDR_W'(w), "R1 final state");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule